// File: doc/BRIEF.md
# Three-Phase Hall Commutation Controller

This block drives the six switches of a three-phase brushless motor bridge from three digitised Hall sensor levels. The Hall levels are brought into the clock domain through a two-flop synchroniser. They are then decoded through a fixed six-state commutation table. For each phase the table selects one of three leg states: high side active, low side on, or floating. A direction input chooses between the table and its mirror. The mirror is made by inverting the Hall code before it is decoded.

An external active-low speed input chops only the high-side switch of the phase that the table drives high. While that switch is chopped off, the low side of the same leg conducts, so the current recirculates through the low switch instead of through its body diode. A stop request puts the bridge into short brake. A lock-protection flag or a current-limit flag removes all high-side drive. Each leg waits a parameterised dead time before it turns on a switch whose complement has just turned off. An open-drain tachometer output follows the synchronised level of Hall phase 1.

Top module: `bldc_commutator`

## Requirements
- R1: Forward direction (`fwd_sel`=1, `stop_req`=0, `pwm_in_n`=0, flags clear). `hall_raw` bit 0 is phase 1, bit 1 is phase 2 and bit 2 is phase 3. With `hall_raw` = 101, 001, 011, 010, 110, 100, the active high side is phase 2, 3, 3, 1, 1, 2 and the low-side phase is 1, 1, 2, 2, 3, 3. The third phase floats, with both of its enables low.
- R2: In reverse (`fwd_sel`=0), each Hall code produces the legs that R1 gives for its bitwise complement.
- R3: Hall codes 000 and 111 drive all six enables low when no stop is requested.
- R4: While `pwm_in_n` is high, the phase that R1/R2 drive high has its high side off and its low side on. While `pwm_in_n` is low, that phase's high side is on. Phases in the low or floating state are not affected.
- R5: While `stop_req` is high, all three low sides are on and all high sides are off, whatever the Hall code.
- R6: `tach_pull_low` is 1 exactly when synchronised Hall phase 1 is low. A change on `hall_raw[0]` reaches it after two clock edges.
- R7: After a switch of a leg turns off, its complement turns on no sooner than DEAD_CYC+1 cycles later (exactly that many when requested at once). High and low side of a leg are never on together.
- R8: When `lock_trip` or `ilim_trip` is high, all high sides are off and the phase that would be driven high floats. The low-side phase of the table stays on.
- R9: During reset all enables are low and `tach_pull_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_raw | input | 3 | Asynchronous Hall levels, bit 0 = phase 1 |
| fwd_sel | input | 1 | 1 = forward table, 0 = reverse |
| stop_req | input | 1 | 1 = short brake |
| pwm_in_n | input | 1 | Active-low speed chop for the driven-high phase |
| lock_trip | input | 1 | Lock protection active, blocks high sides |
| ilim_trip | input | 1 | Current limit active, blocks high sides |
| hs_en | output | 3 | High-side gate enables, bit n = phase n+1 |
| ls_en | output | 3 | Low-side gate enables, bit n = phase n+1 |
| tach_pull_low | output | 1 | Open-drain tachometer: 1 = pull low |

## Verification
The bench walks all six legal Hall codes in both directions. This separates a wrong table row from a wrong direction mirror, because each reverse code lands on a different forward row. The illegal codes 000 and 111 are applied both with and without stop, which shows the precedence of brake over the all-off rule. The speed input is toggled around a steady code, cycle by cycle, so the dead-time count and the hand-over to synchronous rectification can be seen. The two protection flags are each raised alone to show that they remove only high-side drive. A single-bit Hall step measures the synchroniser latency at the tachometer pin.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_HI  = 2'd1,
    PH_LO  = 2'd2
  } phase_e;

  // Commutation for the forward direction. h[0] is phase 1.
  // Result packs phase n state into bits [2n+1:2n].
  function automatic logic [5:0] comm_row(input logic [2:0] h);
    logic [5:0] r;
    case (h)
      3'b101:  r = {PH_OFF, PH_HI,  PH_LO };
      3'b001:  r = {PH_HI,  PH_OFF, PH_LO };
      3'b011:  r = {PH_HI,  PH_LO,  PH_OFF};
      3'b010:  r = {PH_OFF, PH_LO,  PH_HI };
      3'b110:  r = {PH_LO,  PH_OFF, PH_HI };
      3'b100:  r = {PH_LO,  PH_HI,  PH_OFF};
      default: r = {PH_OFF, PH_OFF, PH_OFF};
    endcase
    return r;
  endfunction

  function automatic logic code_illegal(input logic [2:0] h);
    return (h == 3'b000) || (h == 3'b111);
  endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/comm_decode.sv
module comm_decode
  import bldc_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hall_s,
  input  logic           fwd_sel,
  input  logic           stop_req,
  input  logic           pwm_in_n,
  input  logic           hs_block,
  output logic [NPH-1:0] want_hs,
  output logic [NPH-1:0] want_ls,
  output logic           illegal
);
  logic [NPH-1:0] code;
  logic [5:0]     row;

  assign code    = fwd_sel ? hall_s : ~hall_s;
  assign row     = comm_row(code);
  assign illegal = code_illegal(code);

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    phase_e st;
    assign st = phase_e'(row[2*p +: 2]);

    always_comb begin
      want_hs[p] = 1'b0;
      want_ls[p] = 1'b0;
      if (stop_req) begin
        want_ls[p] = 1'b1;
      end else begin
        case (st)
          PH_HI: begin
            want_hs[p] = !pwm_in_n && !hs_block;
            want_ls[p] = pwm_in_n && !hs_block;
          end
          PH_LO:   want_ls[p] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R7 support: requests to a leg are mutually exclusive
  a_r7_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (want_hs & want_ls) == '0);
endmodule

// File: rtl/leg_drive.sv
module leg_drive #(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hs,
  input  logic want_ls,
  output logic hs_q,
  output logic ls_q
);
  localparam int CW = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [CW-1:0] GAP_DONE = CW'(DEAD_CYC);

  logic [CW-1:0] gap_q;
  logic drop, idle, gap_met;

  assign drop    = (hs_q && !want_hs) || (ls_q && !want_ls);
  assign idle    = !hs_q && !ls_q;
  assign gap_met = gap_q >= GAP_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= GAP_DONE;
    end else if (drop) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= '0;
    end else if (idle) begin
      if (gap_met) begin
        hs_q <= want_hs;
        ls_q <= want_ls;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  a_r7_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));
  a_r7_hs_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> !$past(ls_q));
  a_r7_ls_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> !$past(hs_q));
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator #(
  parameter int DEAD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_raw,
  input  logic       fwd_sel,
  input  logic       stop_req,
  input  logic       pwm_in_n,
  input  logic       lock_trip,
  input  logic       ilim_trip,
  output logic [2:0] hs_en,
  output logic [2:0] ls_en,
  output logic       tach_pull_low
);
  localparam int NPH = 3;

  logic [NPH-1:0] hall_s;
  logic [NPH-1:0] want_hs, want_ls;
  logic           illegal_code;
  logic           hs_block;

  assign hs_block = lock_trip || ilim_trip;

  hall_sync #(.W(NPH), .RST_VAL('1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(hall_raw),
    .q_sync (hall_s)
  );

  comm_decode #(.NPH(NPH)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .hall_s  (hall_s),
    .fwd_sel (fwd_sel),
    .stop_req(stop_req),
    .pwm_in_n(pwm_in_n),
    .hs_block(hs_block),
    .want_hs (want_hs),
    .want_ls (want_ls),
    .illegal (illegal_code)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    leg_drive #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_hs(want_hs[p]),
      .want_ls(want_ls[p]),
      .hs_q   (hs_en[p]),
      .ls_q   (ls_en[p])
    );
  end

  // Open drain: pull low while synchronised phase 1 reads low
  assign tach_pull_low = !hall_s[0];

  a_r3_illegal_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_code && !stop_req) |=> (hs_en == '0) && (ls_en == '0));
  a_r5_brake_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> hs_en == '0);
  a_r8_trip_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    hs_block |=> hs_en == '0);
endmodule

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;
  localparam int DT = 3;
  localparam int SETTLE = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall_raw = 3'b111;
  logic fwd_sel = 1'b1, stop_req = 1'b0, pwm_in_n = 1'b0;
  logic lock_trip = 1'b0, ilim_trip = 1'b0;
  logic [2:0] hs_en, ls_en;
  logic tach_pull_low;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bldc_commutator #(.DEAD_CYC(DT)) uut (
    .clk(clk), .rst_n(rst_n), .hall_raw(hall_raw), .fwd_sel(fwd_sel),
    .stop_req(stop_req), .pwm_in_n(pwm_in_n), .lock_trip(lock_trip),
    .ilim_trip(ilim_trip), .hs_en(hs_en), .ls_en(ls_en),
    .tach_pull_low(tach_pull_low)
  );

  task automatic chk(input string req, input string what,
                     input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // Phase index (1..3) driven high / low for a forward-decoded code,
  // given as individual phase levels in1, in2, in3.
  function automatic int hi_of(input logic i1, input logic i2, input logic i3);
    if ( i1 && !i2 &&  i3) return 2;
    if ( i1 && !i2 && !i3) return 3;
    if ( i1 &&  i2 && !i3) return 3;
    if (!i1 &&  i2 && !i3) return 1;
    if (!i1 &&  i2 &&  i3) return 1;
    if (!i1 && !i2 &&  i3) return 2;
    return 0;
  endfunction

  function automatic int lo_of(input logic i1, input logic i2, input logic i3);
    if (i1 && !i2) return 1;
    if (i2 && !i3) return 2;
    if (i3 && !i1) return 3;
    return 0;
  endfunction

  function automatic logic [2:0] bit_of(input int ph);
    return (ph == 0) ? 3'b000 : 3'(1 << (ph - 1));
  endfunction

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "hs_en in reset", hs_en, 3'b000);
    chk("R9", "ls_en in reset", ls_en, 3'b000);
    chk("R9", "tach in reset", {2'b00, tach_pull_low}, 3'b000);
    rst_n = 1'b1;
  endtask

  task automatic t_table(input logic fwd, input string req);
    logic [2:0] seq [6] = '{3'b101, 3'b001, 3'b011, 3'b010, 3'b110, 3'b100};
    fwd_sel = fwd; pwm_in_n = 1'b0; stop_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      logic [2:0] c;
      c = fwd ? seq[k] : ~seq[k];
      hall_raw = seq[k];
      settle();
      chk(req, $sformatf("hs_en code %b", seq[k]), hs_en, bit_of(hi_of(c[0], c[1], c[2])));
      chk(req, $sformatf("ls_en code %b", seq[k]), ls_en, bit_of(lo_of(c[0], c[1], c[2])));
    end
  endtask

  task automatic t_illegal();
    fwd_sel = 1'b1; stop_req = 1'b0;
    hall_raw = 3'b000; settle();
    chk("R3", "hs_en code 000", hs_en, 3'b000);
    chk("R3", "ls_en code 000", ls_en, 3'b000);
    hall_raw = 3'b111; settle();
    chk("R3", "hs_en code 111", hs_en, 3'b000);
    chk("R3", "ls_en code 111", ls_en, 3'b000);
  endtask

  task automatic t_pwm_dead();
    fwd_sel = 1'b1; pwm_in_n = 1'b0; hall_raw = 3'b101; settle();
    chk("R4", "hs_en chop on", hs_en, 3'b010);
    pwm_in_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7", "hs off one edge after chop", hs_en, 3'b000);
    chk("R7", "ls2 still off at start of gap", ls_en, 3'b001);
    repeat (DT) @(posedge clk);
    @(negedge clk);
    chk("R7", "ls2 off through dead time", ls_en, 3'b001);
    @(posedge clk); @(negedge clk);
    chk("R7", "ls2 on after dead time", ls_en, 3'b011);
    chk("R4", "hs_en chop off", hs_en, 3'b000);
    pwm_in_n = 1'b0;
    repeat (DT + 1) @(posedge clk);
    @(negedge clk);
    chk("R7", "hs2 held off through dead time", hs_en, 3'b000);
    @(posedge clk); @(negedge clk);
    chk("R4", "hs2 back on", hs_en, 3'b010);
    chk("R4", "ls back to table", ls_en, 3'b001);
  endtask

  task automatic t_brake();
    hall_raw = 3'b010; stop_req = 1'b1; settle();
    chk("R5", "hs_en brake", hs_en, 3'b000);
    chk("R5", "ls_en brake", ls_en, 3'b111);
    hall_raw = 3'b000; settle();
    chk("R5", "ls_en brake on code 000", ls_en, 3'b111);
    stop_req = 1'b0; hall_raw = 3'b010; settle();
    chk("R5", "hs_en after release", hs_en, 3'b001);
  endtask

  task automatic t_trips();
    fwd_sel = 1'b1; pwm_in_n = 1'b1; hall_raw = 3'b110;
    lock_trip = 1'b1; settle();
    chk("R8", "hs_en lock", hs_en, 3'b000);
    chk("R8", "ls_en lock", ls_en, 3'b100);
    lock_trip = 1'b0; pwm_in_n = 1'b0; ilim_trip = 1'b1; settle();
    chk("R8", "hs_en ilim", hs_en, 3'b000);
    chk("R8", "ls_en ilim", ls_en, 3'b100);
    ilim_trip = 1'b0; settle();
    chk("R8", "hs_en after trip", hs_en, 3'b001);
  endtask

  task automatic t_tach();
    hall_raw = 3'b100; settle();
    chk("R6", "tach phase1 low", {2'b00, tach_pull_low}, 3'b001);
    hall_raw = 3'b101;
    @(posedge clk); @(negedge clk);
    chk("R6", "tach after one edge", {2'b00, tach_pull_low}, 3'b001);
    @(posedge clk); @(negedge clk);
    chk("R6", "tach after two edges", {2'b00, tach_pull_low}, 3'b000);
  endtask

  initial begin
    t_reset();
    repeat (4) @(posedge clk);
    t_table(1'b1, "R1");
    t_table(1'b0, "R2");
    t_illegal();
    t_pwm_dead();
    t_brake();
    t_trips();
    t_tach();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule